// File: doc/BRIEF.md
# I2C Configuration Register Target with Byte and Block Access

This block lets an I2C controller read and write a 64-entry byte-wide configuration store. It answers to a 7-bit address whose upper five bits are fixed and whose low bits come from a field of the store itself. The block supports standard-mode and fast-mode bus rates. SCL and SDA are oversampled by the system clock, and the block pulls SDA low through an open-drain enable.

A write transaction sends the address and then a command byte. Bit 7 of the command picks the access kind. When it is 1, the access is a single byte. When it is 0, the access is a sequential block. The low bits of the command hold the starting offset. Write data goes to the store as soon as each byte completes. To read, the controller sends a command, then a repeated START, then the address with the read bit set. In block mode the number of bytes returned comes from a count field held in the store.

An external commit-busy flag blocks writes while stored settings are being saved to non-volatile memory. During that time reads still work.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges an address byte only when its bits 7:3 are 11011 and its bits 2:1 equal `addr_sel`. Any other address is not acknowledged, and the target ignores all bytes until the next START.
- R2: A command byte with bit 7 = 1 selects byte mode. Exactly one data byte is written, at offset = command bits 5:0. Command bit 6 is ignored. A second data byte in the same transaction is not acknowledged, and the store is left unchanged.
- R3: A command byte with bit 7 = 0 selects block mode. Successive data bytes are written at successive offsets starting from command bits 5:0, and the offset wraps from 3Fh to 00h.
- R4: Each accepted data byte produces exactly one single-cycle `wr_en` strobe carrying its offset and value. A value written to the store takes effect at once, including the address-select and count fields.
- R5: While `commit_busy` is high at a data byte's acknowledge point, the byte is not acknowledged and no strobe is issued. Command bytes and reads are served as usual.
- R6: A byte read is a command in byte mode, then a repeated START, then a read address. It returns the store byte at the commanded offset.
- R7: A block read returns exactly `rd_count` bytes, most significant bit first, from the commanded offset upward with wrap. After the last byte, SDA stays released even if the controller acknowledges.
- R8: A repeated START restarts address decoding. A STOP returns the target to idle with SDA released. Reset leaves SDA released and `wr_en` low.
- R9: `sda_oe` starts driving only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Programmable low address bits, from the store |
| rd_count | input | 7 | Block read length, from the store |
| commit_busy | input | 1 | Non-volatile save in progress; refuses writes |
| rd_ofs | output | 6 | Read offset into the store |
| rd_data | input | 8 | Store byte at `rd_ofs`, combinational |
| wr_en | output | 1 | One-cycle write strobe |
| wr_ofs | output | 6 | Write offset |
| wr_data | output | 8 | Write value |

## Verification
Two events can land on the same clock edge: the acknowledge decision for a received data byte, and a rise of the commit-busy flag. In one scenario the bench holds busy high across a write transaction. It expects the command to be acknowledged, the data byte to be refused, no strobe to appear, and the target register to keep its value. A read issued while busy is still high must return stored data. The bench also writes the count field and issues a block read right after it, which shows that the new length governs the very next transfer.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXACK,
      ST_TX,
      ST_TXACK,
      ST_WAIT
   } phase_e;

   typedef enum logic [1:0] {
      K_ADDR,
      K_CMD,
      K_DATA
   } kind_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic ev_rise,
   output logic ev_fall,
   output logic ev_start,
   output logic ev_stop
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign ev_rise  = scl_s & ~scl_q;
   assign ev_fall  = ~scl_s & scl_q;
   assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
   assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         shin_en,
   input  logic         bit_in,
   input  logic         shout_en,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("i2c_byte_shift: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (load_en)  q <= load_val;
      else if (shin_en)  q <= {q[W-2:0], bit_in};
      else if (shout_en) q <= {q[W-2:0], 1'b1};
   end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
   import i2c_cfg_pkg::*;
#(
   parameter int         OFS_W       = 6,
   parameter int         CNT_W       = 7,
   parameter int         SEL_W       = 2,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] ADDR_BASE   = 7'h6C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             sda_oe,
   input  logic [SEL_W-1:0] addr_sel,
   input  logic [CNT_W-1:0] rd_count,
   input  logic             commit_busy,
   output logic [OFS_W-1:0] rd_ofs,
   input  logic [7:0]       rd_data,
   output logic             wr_en,
   output logic [OFS_W-1:0] wr_ofs,
   output logic [7:0]       wr_data
);
   localparam int BITS_W = $clog2(BYTE_W + 1);

   if (OFS_W < 1 || OFS_W > 7) begin : g_bad_ofs
      $error("i2c_cfg_target: OFS_W must be 1..7");
   end
   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("i2c_cfg_target: SEL_W must be 1..6");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("i2c_cfg_target: CNT_W must be 1..8");
   end

   logic scl_s, sda_s;
   logic ev_rise, ev_fall, ev_start, ev_stop;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
   );
   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );
   i2c_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .ev_rise(ev_rise), .ev_fall(ev_fall),
      .ev_start(ev_start), .ev_stop(ev_stop)
   );

   phase_e             st;
   kind_e              kind;
   logic [BITS_W-1:0]  bcnt;
   logic [OFS_W-1:0]   ptr;
   logic [CNT_W-1:0]   left;
   logic               blk_mode, rd_dir, wrote_one, mack;
   logic [7:0]         sh_q;

   logic [6:0]         rx_addr;
   logic               addr_hit, take_byte, rd_first, rd_more, load_now;
   logic [CNT_W-1:0]   first_len;

   assign rx_addr  = sh_q[7:1];
   assign addr_hit = (rx_addr[6:SEL_W] == ADDR_BASE[6:SEL_W]) &&
                     (rx_addr[SEL_W-1:0] == addr_sel);

   always_comb begin
      case (kind)
         K_ADDR:  take_byte = addr_hit;
         K_CMD:   take_byte = 1'b1;
         default: take_byte = !commit_busy && (blk_mode || !wrote_one);
      endcase
   end

   assign first_len = blk_mode ? rd_count : CNT_W'(1);
   assign rd_first  = (st == ST_RXACK) && ev_fall && (kind == K_ADDR) &&
                      rd_dir && (first_len != '0);
   assign rd_more   = (st == ST_TXACK) && ev_fall && mack && (left != '0);
   assign load_now  = !ev_start && !ev_stop && (rd_first || rd_more);

   i2c_byte_shift #(.W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_now),
      .load_val (rd_data),
      .shin_en  ((st == ST_RX) && ev_rise && (bcnt < BITS_W'(BYTE_W))),
      .bit_in   (sda_s),
      .shout_en ((st == ST_TX) && ev_fall),
      .q        (sh_q)
   );

   assign rd_ofs = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         kind      <= K_ADDR;
         bcnt      <= '0;
         ptr       <= '0;
         left      <= '0;
         blk_mode  <= 1'b0;
         rd_dir    <= 1'b0;
         wrote_one <= 1'b0;
         mack      <= 1'b0;
         sda_oe    <= 1'b0;
         wr_en     <= 1'b0;
         wr_ofs    <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (ev_start) begin
            st     <= ST_RX;
            kind   <= K_ADDR;
            bcnt   <= '0;
            sda_oe <= 1'b0;
         end else if (ev_stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (ev_rise && bcnt < BITS_W'(BYTE_W)) begin
                     bcnt <= bcnt + 1'b1;
                  end else if (ev_fall && bcnt == BITS_W'(BYTE_W)) begin
                     if (take_byte) begin
                        sda_oe <= 1'b1;
                        st     <= ST_RXACK;
                        case (kind)
                           K_ADDR: rd_dir <= sh_q[0];
                           K_CMD: begin
                              blk_mode  <= ~sh_q[7];
                              ptr       <= sh_q[OFS_W-1:0];
                              wrote_one <= 1'b0;
                           end
                           default: begin
                              wr_en     <= 1'b1;
                              wr_ofs    <= ptr;
                              wr_data   <= sh_q;
                              wrote_one <= 1'b1;
                              if (blk_mode) ptr <= ptr + 1'b1;
                           end
                        endcase
                     end else begin
                        st <= ST_WAIT;
                     end
                  end
               end
               ST_RXACK: begin
                  if (ev_fall) begin
                     bcnt <= '0;
                     if (kind == K_ADDR && rd_dir) begin
                        if (rd_first) begin
                           st     <= ST_TX;
                           left   <= first_len - 1'b1;
                           sda_oe <= ~rd_data[7];
                           if (blk_mode) ptr <= ptr + 1'b1;
                        end else begin
                           st     <= ST_WAIT;
                           sda_oe <= 1'b0;
                        end
                     end else begin
                        st     <= ST_RX;
                        kind   <= (kind == K_ADDR) ? K_CMD : K_DATA;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (ev_fall) begin
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == BITS_W'(BYTE_W - 1)) begin
                        sda_oe <= 1'b0;
                        st     <= ST_TXACK;
                     end else begin
                        sda_oe <= ~sh_q[6];
                     end
                  end
               end
               ST_TXACK: begin
                  if (ev_rise) begin
                     mack <= ~sda_s;
                  end else if (ev_fall) begin
                     bcnt <= '0;
                     if (rd_more) begin
                        st     <= ST_TX;
                        left   <= left - 1'b1;
                        sda_oe <= ~rd_data[7];
                        if (blk_mode) ptr <= ptr + 1'b1;
                     end else begin
                        st     <= ST_WAIT;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_WRITE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$past(commit_busy)); // R5
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R4
   AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s); // R9
   AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TXACK && ev_fall && left == '0) |=> (st == ST_WAIT && !sda_oe)); // R7
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (!sda_oe && st == ST_IDLE)); // R8
endmodule

// File: tb/i2c_cfg_target_bench.sv
module i2c_cfg_target_bench;
   localparam int H = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
   logic sda_oe, wr_en;
   logic [5:0] rd_ofs, wr_ofs;
   logic [7:0] wr_data;
   logic [7:0] mem [64];
   wire  sda_line = sda_m & ~sda_oe;

   int checks = 0, fails = 0, we_cnt = 0, r9_bad = 0;
   logic prev_oe = 1'b0;
   logic finished = 1'b0;

   i2c_cfg_target u_i2c_cfg_target (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_oe(sda_oe), .addr_sel(mem[1][1:0]), .rd_count(mem[6][7:1]),
      .commit_busy(busy), .rd_ofs(rd_ofs), .rd_data(mem[rd_ofs]),
      .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
         mem[1] <= 8'h01;
         mem[6] <= 8'h80;
      end else if (wr_en) begin
         mem[wr_ofs] <= wr_data;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) we_cnt++;
         if (sda_oe != prev_oe && scl_m) r9_bad++;
      end
      prev_oe <= sda_oe;
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wc(H); scl_m = 1'b1; wc(H); scl_m = 1'b0; wc(2);
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; wc(H); scl_m = 1'b1; wc(H/2); b = sda_line;
      wc(H/2); scl_m = 1'b0; wc(2);
   endtask

   task automatic start_c();
      sda_m = 1'b1; wc(H); scl_m = 1'b1; wc(H); sda_m = 1'b0; wc(H);
      scl_m = 1'b0; wc(2);
   endtask

   task automatic stop_c();
      sda_m = 1'b0; wc(H); scl_m = 1'b1; wc(H); sda_m = 1'b1; wc(H);
   endtask

   task automatic send(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(b);
      ack = !b;
   endtask

   task automatic recv(output logic [7:0] v, input logic mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         v[i] = b;
      end
      bit_out(!mack);
   endtask

   task automatic t_reset();
      chk(sda_oe == 1'b0, "R8 reset sda_oe", sda_oe, 0);
      chk(wr_en == 1'b0, "R8 reset wr_en", wr_en, 0);
   endtask

   task automatic t_addr_miss();
      logic a;
      start_c(); send(8'hDC, a);
      chk(!a, "R1 wrong address acked", a, 0);
      send(8'h90, a);
      chk(!a, "R1 byte after miss acked", a, 0);
      stop_c();
   endtask

   task automatic t_byte_write();
      logic a0, a1, a2, a3;
      int w0 = we_cnt;
      start_c(); send(8'hDA, a0); send(8'hD0, a1); send(8'h5A, a2); send(8'h77, a3); stop_c();
      chk(a0 && a1 && a2, "R2 byte write acks", {a0, a1, a2}, 7);
      chk(!a3, "R2 second data byte acked", a3, 0);
      chk(mem[16] == 8'h5A, "R2 mem[10h]", mem[16], 8'h5A);
      chk(mem[17] == 8'h00, "R2 mem[11h] touched", mem[17], 0);
      chk(we_cnt - w0 == 1, "R4 strobes per byte write", we_cnt - w0, 1);
   endtask

   task automatic t_block_write();
      logic a0, a1, a2, a3, a4;
      int w0 = we_cnt;
      start_c(); send(8'hDA, a0); send(8'h3E, a1);
      send(8'hA1, a2); send(8'hA2, a3); send(8'hA3, a4); stop_c();
      chk(a0 && a1 && a2 && a3 && a4, "R3 block acks", {a0, a1, a2, a3, a4}, 31);
      chk(mem[62] == 8'hA1, "R3 mem[3Eh]", mem[62], 8'hA1);
      chk(mem[63] == 8'hA2, "R3 mem[3Fh]", mem[63], 8'hA2);
      chk(mem[0] == 8'hA3, "R3 wrap mem[00h]", mem[0], 8'hA3);
      chk(we_cnt - w0 == 3, "R4 strobes per block", we_cnt - w0, 3);
   endtask

   task automatic byte_read(input logic [7:0] addr_w, input logic [7:0] cmd,
                            output logic [7:0] v, output logic ok);
      logic a0, a1, a2;
      start_c(); send(addr_w, a0); send(cmd, a1);
      start_c(); send(addr_w | 8'h01, a2); recv(v, 1'b0); stop_c();
      ok = a0 && a1 && a2;
   endtask

   task automatic t_busy();
      logic a0, a1, a2, ok;
      logic [7:0] v;
      int w0 = we_cnt;
      busy = 1'b1;
      start_c(); send(8'hDA, a0); send(8'hA0, a1); send(8'h33, a2); stop_c();
      chk(a0 && a1, "R5 addr/cmd acked while busy", {a0, a1}, 3);
      chk(!a2, "R5 data acked while busy", a2, 0);
      chk(mem[32] == 8'h00, "R5 mem[20h] written while busy", mem[32], 0);
      chk(we_cnt == w0, "R5 strobe while busy", we_cnt - w0, 0);
      byte_read(8'hDA, 8'h90, v, ok);
      chk(ok && v == 8'h5A, "R5 read while busy", v, 8'h5A);
      busy = 1'b0;
   endtask

   task automatic t_byte_read();
      logic ok;
      logic [7:0] v;
      byte_read(8'hDA, 8'hBE, v, ok);
      chk(ok && v == 8'hA1, "R6 byte read 3Eh", v, 8'hA1);
   endtask

   task automatic t_block_read();
      logic a0, a1, a2, a3;
      logic [7:0] v0, v1, v2, v3;
      start_c(); send(8'hDA, a0); send(8'h86, a1); send(8'h06, a2); stop_c();
      chk(mem[6] == 8'h06, "R4 count field write", mem[6], 8'h06);
      start_c(); send(8'hDA, a0); send(8'h3E, a1);
      start_c(); send(8'hDB, a3);
      recv(v0, 1'b1); recv(v1, 1'b1); recv(v2, 1'b1); recv(v3, 1'b0); stop_c();
      chk(a0 && a1 && a3, "R7 block read acks", {a0, a1, a3}, 7);
      chk(v0 == 8'hA1, "R7 byte0", v0, 8'hA1);
      chk(v1 == 8'hA2, "R7 byte1", v1, 8'hA2);
      chk(v2 == 8'hA3, "R7 byte2 wrapped", v2, 8'hA3);
      chk(v3 == 8'hFF, "R7 bus released after count", v3, 8'hFF);
   endtask

   task automatic t_addr_prog();
      logic a0, a1, a2, b0, b1;
      start_c(); send(8'hDA, a0); send(8'h81, a1); send(8'h02, a2); stop_c();
      chk(a0 && a1 && a2, "R4 addr_sel write acks", {a0, a1, a2}, 7);
      start_c(); send(8'hDA, b0); stop_c();
      chk(!b0, "R1 old address acked", b0, 0);
      start_c(); send(8'hDC, b1); stop_c();
      chk(b1, "R1 new address refused", b1, 1);
   endtask

   task automatic t_restart();
      logic a0, a1, a2, a3;
      logic [7:0] v;
      start_c(); send(8'hDC, a0); send(8'h90, a1);
      start_c(); send(8'hDA, a2);
      start_c(); send(8'hDD, a3); recv(v, 1'b0); stop_c();
      chk(a0 && a1, "R8 first phase acks", {a0, a1}, 3);
      chk(!a2, "R8 restart mismatched address acked", a2, 0);
      chk(a3 && v == 8'h5A, "R8 restart read", v, 8'h5A);
      wc(4);
      chk(sda_oe == 1'b0, "R8 released after STOP", sda_oe, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      wc(5);
      rst_n = 1'b1;
      wc(5);
      t_reset();
      t_addr_miss();
      t_byte_write();
      t_block_write();
      t_busy();
      t_byte_read();
      t_block_read();
      t_addr_prog();
      t_restart();
      chk(r9_bad == 0, "R9 drive change while SCL high", r9_bad, 0);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule